// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the front end of a transmit DMA channel. It holds a ring of buffer descriptors in local register storage. Software fills the descriptors through a word-addressed register port and then moves a 16-bit producer index forward. The engine compares that index with its own 16-bit consumer index. While the two differ, it reads the descriptor at the current ring position and decodes the buffer address, the length and the framing flags. It then offers the result as a transmit job on a valid/ready handshake.

Once a job has been accepted, the engine waits for a one-cycle completion pulse from the downstream data mover. On that pulse it adds one to the consumer index and moves to the next ring slot. Both indices run freely modulo 2^16. The ring slot is the low bits of the consumer index, so the slot wraps from the last entry back to zero on its own. Nothing is fetched unless the global enable bit and the ring enable bit are both set. Software clears pending work by turning off the global enable and then writing the flush register.

Top module: `txr_engine`

## Requirements
- R1: After reset, job_valid is 0, and the producer index, consumer index and control register all read as 0.
- R2: Descriptor d, for d from 0 to 255, occupies register words 3d (length/status), 3d+1 (address bits 31:0) and 3d+2 (address bits 63:32). These words read back exactly as written. The control register is at word 768, the producer index at 769, the consumer index at 770 and the flush register at 771.
- R3: A job is offered only while control bit 0 (global enable) and control bit 17 (ring enable) are both 1 and the producer index differs from the consumer index. With either enable bit clear, job_valid stays 0.
- R4: An offered job carries address {word 3d+2, word 3d+1} and a length equal to bits 27:16 of the length/status word. It also carries SOP from bit 13, EOP from bit 14 and append-CRC from bit 6. The OWN bit (15) and the queue tag (bits 12:7) do not affect the job.
- R5: Jobs are offered in ring order, starting at slot (consumer index mod 256). The slot after 255 is 0.
- R6: Once job_valid is 1, it and every job field hold steady until job_ready is sampled high.
- R7: A job_done pulse after a job has been accepted increases the consumer index by exactly one. A job_done pulse at any other time is ignored.
- R8: The producer and consumer indices are 16 bits wide and wrap from 0xFFFF to 0x0000. Pending work is decided by their equality modulo 2^16.
- R9: Writing 1 to bit 0 of the flush register while control bit 0 is 0 clears both indices to 0 and withdraws any offered job. While control bit 0 is 1, such a write has no effect.
- R10: The consumer index can be written only while control bit 0 is 0. A write while it is 1 is ignored. The producer index can be written at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| job_valid | output | 1 | Transmit job offered |
| job_ready | input | 1 | Downstream accepts the offered job |
| job_addr | output | 64 | Buffer address of the job |
| job_len | output | 12 | Buffer length in bytes |
| job_sop | output | 1 | Start-of-packet flag |
| job_eop | output | 1 | End-of-packet flag |
| job_crc | output | 1 | Append-CRC request |
| job_done | input | 1 | One-cycle pulse: accepted job has finished |

## Verification
The bench drives the indices across the 16-bit boundary while the ring slot crosses 255 to 0. A design that took the slot from a separately wrapped counter, or that compared the indices with a magnitude test, would stall or replay entries there. It offers jobs with only one of the two enable bits set, and it holds ready low for several cycles. A design that checked only one bit would transmit too early, and one that dropped valid would lose a frame. It pulses done while no job is in flight, and it writes flush and the consumer index while DMA is enabled. A design that honoured any of these would corrupt the consumer count. It also withdraws an offered job by flushing and checks that the indices return to zero.

// File: rtl/txr_pkg.sv
package txr_pkg;
   // Field positions inside the length/status descriptor word
   localparam int LEN_LSB  = 16;
   localparam int OWN_BIT  = 15;
   localparam int EOP_BIT  = 14;
   localparam int SOP_BIT  = 13;
   localparam int QTAG_LSB = 7;
   localparam int QTAG_W   = 6;
   localparam int CRC_BIT  = 6;

   // Number of 32-bit words per descriptor
   localparam int DESC_WPE = 3;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_OFFER = 2'd1,
      FS_BUSY  = 2'd2
   } fetch_state_e;
endpackage

// File: rtl/txr_desc_store.sv
module txr_desc_store #(
   parameter int DEPTH = 256,
   parameter int DW    = 32,
   parameter int AW    = 10,
   parameter int PW    = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [AW-1:0]                   wr_idx,
   input  logic [DW-1:0]                   wr_data,
   input  logic [AW-1:0]                   rd_idx,
   output logic [DW-1:0]                   rd_data,
   input  logic [PW-1:0]                   fetch_ptr,
   output logic [txr_pkg::DESC_WPE-1:0][DW-1:0] fetch_words
);
   localparam int WORDS = txr_pkg::DESC_WPE * DEPTH;

   if (AW <= PW) begin : g_bad_aw
      $fatal(1, "txr_desc_store: AW must exceed PW");
   end

   logic [DW-1:0] mem_q [WORDS];
   logic [AW-1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      end else if (wr_en && (wr_idx < AW'(WORDS))) begin
         mem_q[wr_idx] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_idx < AW'(WORDS)) rd_data = mem_q[rd_idx];
   end

   assign base = {{(AW-PW){1'b0}}, fetch_ptr} * AW'(txr_pkg::DESC_WPE);

   for (genvar k = 0; k < txr_pkg::DESC_WPE; k++) begin : g_fetch
      assign fetch_words[k] = mem_q[base + AW'(k)];
   end
endmodule

// File: rtl/txr_desc_decode.sv
module txr_desc_decode #(
   parameter int DW     = 32,
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 12
) (
   input  logic [txr_pkg::DESC_WPE-1:0][DW-1:0] words,
   output logic [ADDR_W-1:0]                     dec_addr,
   output logic [LEN_W-1:0]                      dec_len,
   output logic                                  dec_sop,
   output logic                                  dec_eop,
   output logic                                  dec_crc
);
   import txr_pkg::*;

   if (ADDR_W < 1 || ADDR_W > 2*DW) begin : g_bad_addr
      $fatal(1, "txr_desc_decode: ADDR_W out of range");
   end
   if (LEN_LSB + LEN_W > DW) begin : g_bad_len
      $fatal(1, "txr_desc_decode: length field overflows word");
   end

   // Address width picks how much of the high word is used
   if (ADDR_W > DW) begin : g_wide_addr
      assign dec_addr = {words[2][ADDR_W-DW-1:0], words[1]};
   end else begin : g_narrow_addr
      assign dec_addr = words[1][ADDR_W-1:0];
   end

   assign dec_len = words[0][LEN_LSB +: LEN_W];
   assign dec_sop = words[0][SOP_BIT];
   assign dec_eop = words[0][EOP_BIT];
   assign dec_crc = words[0][CRC_BIT];

   // Ownership and queue-tag bits carry no meaning for the job
   logic unused_fields;
   assign unused_fields = ^{words[0], words[2]};
endmodule

// File: rtl/txr_index_ctrl.sv
module txr_index_ctrl #(
   parameter int IDX_W = 16,
   parameter int PW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dma_on,
   input  logic             prod_we,
   input  logic             cons_we,
   input  logic [IDX_W-1:0] wdata,
   input  logic             flush_req,
   input  logic             done_ok,
   output logic [IDX_W-1:0] prod,
   output logic [IDX_W-1:0] cons,
   output logic [PW-1:0]    ptr,
   output logic             pend,
   output logic             flush_go
);
   if (IDX_W < PW) begin : g_bad_idx
      $fatal(1, "txr_index_ctrl: index narrower than ring pointer");
   end

   logic [IDX_W-1:0] prod_q, cons_q;
   logic             cons_wr_ok;

   assign flush_go   = flush_req && !dma_on;
   assign cons_wr_ok = cons_we && !dma_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod_q <= '0;
         cons_q <= '0;
      end else if (flush_go) begin
         prod_q <= '0;
         cons_q <= '0;
      end else begin
         if (prod_we) prod_q <= wdata;
         if (cons_wr_ok)   cons_q <= wdata;
         else if (done_ok) cons_q <= cons_q + 1'b1;
      end
   end

   assign prod = prod_q;
   assign cons = cons_q;
   assign pend = (prod_q != cons_q);

   // Ring slot follows the consumer index; it wraps at the ring depth by width
   if (IDX_W == PW) begin : g_ptr_full
      assign ptr = cons_q;
   end else begin : g_ptr_slice
      assign ptr = cons_q[PW-1:0];
   end

   // R7
   cons_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok && !flush_go && !cons_wr_ok) |=> (cons_q == $past(cons_q) + 1'b1));
   // R7
   cons_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_ok && !flush_go && !cons_wr_ok) |=> $stable(cons_q));
endmodule

// File: rtl/txr_job_fetch.sv
module txr_job_fetch #(
   parameter int ADDR_W = 64,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              pend,
   input  logic              flush_go,
   input  logic [ADDR_W-1:0] dec_addr,
   input  logic [LEN_W-1:0]  dec_len,
   input  logic              dec_sop,
   input  logic              dec_eop,
   input  logic              dec_crc,
   input  logic              job_ready,
   input  logic              job_done,
   output logic              job_valid,
   output logic [ADDR_W-1:0] job_addr,
   output logic [LEN_W-1:0]  job_len,
   output logic              job_sop,
   output logic              job_eop,
   output logic              job_crc,
   output logic              done_ok
);
   import txr_pkg::*;

   fetch_state_e      state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  len_q;
   logic              sop_q, eop_q, crc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         addr_q  <= '0;
         len_q   <= '0;
         sop_q   <= 1'b0;
         eop_q   <= 1'b0;
         crc_q   <= 1'b0;
      end else if (flush_go) begin
         state_q <= FS_IDLE;
      end else begin
         unique case (state_q)
            FS_IDLE: if (run_en && pend) begin
               addr_q  <= dec_addr;
               len_q   <= dec_len;
               sop_q   <= dec_sop;
               eop_q   <= dec_eop;
               crc_q   <= dec_crc;
               state_q <= FS_OFFER;
            end
            FS_OFFER: if (job_ready) state_q <= FS_BUSY;
            FS_BUSY:  if (job_done)  state_q <= FS_IDLE;
            default:  state_q <= FS_IDLE;
         endcase
      end
   end

   assign job_valid = (state_q == FS_OFFER);
   assign job_addr  = addr_q;
   assign job_len   = len_q;
   assign job_sop   = sop_q;
   assign job_eop   = eop_q;
   assign job_crc   = crc_q;
   assign done_ok   = (state_q == FS_BUSY) && job_done;

   // R6
   valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (job_valid && !job_ready && !flush_go) |=>
         (job_valid && $stable(job_addr) && $stable(job_len) &&
          $stable(job_sop) && $stable(job_eop) && $stable(job_crc)));
   // R3
   start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(job_valid) |-> $past(run_en && pend));
endmodule

// File: rtl/txr_engine.sv
module txr_engine #(
   parameter int RING_DEPTH = 256,
   parameter int IDX_W      = 16,
   parameter int ADDR_W     = 64,
   parameter int LEN_W      = 12,
   parameter int QUEUE_ID   = 16,
   localparam int DW        = 32,
   localparam int WORDS     = txr_pkg::DESC_WPE * RING_DEPTH,
   localparam int REG_AW    = $clog2(WORDS + 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   output logic              job_valid,
   input  logic              job_ready,
   output logic [ADDR_W-1:0] job_addr,
   output logic [LEN_W-1:0]  job_len,
   output logic              job_sop,
   output logic              job_eop,
   output logic              job_crc,
   input  logic              job_done
);
   localparam int PW          = $clog2(RING_DEPTH);
   localparam int RING_EN_BIT = QUEUE_ID + 1;
   localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(WORDS);
   localparam logic [REG_AW-1:0] A_PROD  = REG_AW'(WORDS + 1);
   localparam logic [REG_AW-1:0] A_CONS  = REG_AW'(WORDS + 2);
   localparam logic [REG_AW-1:0] A_FLUSH = REG_AW'(WORDS + 3);

   if (RING_DEPTH < 2 || (RING_DEPTH & (RING_DEPTH - 1)) != 0) begin : g_bad_depth
      $fatal(1, "txr_engine: RING_DEPTH must be a power of two");
   end
   if (RING_EN_BIT < 1 || RING_EN_BIT >= DW) begin : g_bad_queue
      $fatal(1, "txr_engine: ring enable bit outside control word");
   end
   if (IDX_W > DW) begin : g_bad_idxw
      $fatal(1, "txr_engine: index wider than register word");
   end

   logic [DW-1:0]    ctrl_q;
   logic             dma_on, run_en;
   logic [IDX_W-1:0] prod, cons;
   logic [PW-1:0]    ptr;
   logic             pend, flush_go, done_ok;
   logic [DW-1:0]    store_rdata;
   logic [txr_pkg::DESC_WPE-1:0][DW-1:0] fwords;
   logic [ADDR_W-1:0] dec_addr;
   logic [LEN_W-1:0]  dec_len;
   logic              dec_sop, dec_eop, dec_crc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ctrl_q <= '0;
      else if (reg_we && reg_addr == A_CTRL) ctrl_q <= reg_wdata;
   end

   assign dma_on = ctrl_q[0];
   assign run_en = ctrl_q[0] && ctrl_q[RING_EN_BIT];

   txr_desc_store #(
      .DEPTH(RING_DEPTH), .DW(DW), .AW(REG_AW), .PW(PW)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_we && (reg_addr < A_CTRL)),
      .wr_idx     (reg_addr),
      .wr_data    (reg_wdata),
      .rd_idx     (reg_addr),
      .rd_data    (store_rdata),
      .fetch_ptr  (ptr),
      .fetch_words(fwords)
   );

   txr_desc_decode #(
      .DW(DW), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
   ) u_decode (
      .words   (fwords),
      .dec_addr(dec_addr),
      .dec_len (dec_len),
      .dec_sop (dec_sop),
      .dec_eop (dec_eop),
      .dec_crc (dec_crc)
   );

   txr_index_ctrl #(
      .IDX_W(IDX_W), .PW(PW)
   ) u_index (
      .clk      (clk),
      .rst_n    (rst_n),
      .dma_on   (dma_on),
      .prod_we  (reg_we && reg_addr == A_PROD),
      .cons_we  (reg_we && reg_addr == A_CONS),
      .wdata    (reg_wdata[IDX_W-1:0]),
      .flush_req(reg_we && reg_addr == A_FLUSH && reg_wdata[0]),
      .done_ok  (done_ok),
      .prod     (prod),
      .cons     (cons),
      .ptr      (ptr),
      .pend     (pend),
      .flush_go (flush_go)
   );

   txr_job_fetch #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W)
   ) u_fetch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .pend     (pend),
      .flush_go (flush_go),
      .dec_addr (dec_addr),
      .dec_len  (dec_len),
      .dec_sop  (dec_sop),
      .dec_eop  (dec_eop),
      .dec_crc  (dec_crc),
      .job_ready(job_ready),
      .job_done (job_done),
      .job_valid(job_valid),
      .job_addr (job_addr),
      .job_len  (job_len),
      .job_sop  (job_sop),
      .job_eop  (job_eop),
      .job_crc  (job_crc),
      .done_ok  (done_ok)
   );

   always_comb begin
      if (reg_addr < A_CTRL)       reg_rdata = store_rdata;
      else if (reg_addr == A_CTRL) reg_rdata = ctrl_q;
      else if (reg_addr == A_PROD) reg_rdata = DW'(prod);
      else if (reg_addr == A_CONS) reg_rdata = DW'(cons);
      else                         reg_rdata = '0;
   end

   // R9
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_go |=> (!job_valid && prod == '0 && cons == '0));
   // R3
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !job_valid) |=> !job_valid);
endmodule

// File: tb/txr_engine_tb.sv
module txr_engine_tb;
   localparam int A_CTRL  = 768;
   localparam int A_PROD  = 769;
   localparam int A_CONS  = 770;
   localparam int A_FLUSH = 771;
   localparam logic [31:0] RUN = 32'h0002_0001;

   typedef struct packed {
      logic [63:0] a;
      logic [11:0] l;
      logic        s, e, c;
   } job_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [9:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        job_valid, job_ready, job_done;
   logic [63:0] job_addr;
   logic [11:0] job_len;
   logic        job_sop, job_eop, job_crc;

   int   n_chk = 0, n_fail = 0;
   int   acc_cnt = 0, done_cnt = 0;
   job_t exp_q[$];
   logic rdy = 1'b1, auto_d = 1'b0, man_d = 1'b0, hold_en = 1'b1;
   bit   finished = 0;

   always #2 clk = ~clk;
   assign job_ready = rdy;
   assign job_done  = auto_d | man_d;

   txr_engine u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .job_valid(job_valid),
      .job_ready(job_ready), .job_addr(job_addr), .job_len(job_len),
      .job_sop(job_sop), .job_eop(job_eop), .job_crc(job_crc),
      .job_done(job_done)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a[9:0]; reg_wdata = d;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      reg_addr = a[9:0];
      @(negedge clk); d = reg_rdata;
      tick();
   endtask

   function automatic logic [31:0] mk_w0(input logic [11:0] len,
                                         input logic s, input logic e, input logic c);
      // OWN and a full queue tag are set; neither may reach the job (R4)
      return (32'(len) << 16) | 32'h8000 | (32'(e) << 14) | (32'(s) << 13)
             | (32'h3F << 7) | (32'(c) << 6);
   endfunction

   task automatic put_desc(input int pos, input logic [11:0] len, input logic [63:0] a,
                           input logic s, input logic e, input logic c, input bit push);
      job_t j;
      wr(pos*3,     mk_w0(len, s, e, c));
      wr(pos*3 + 1, a[31:0]);
      wr(pos*3 + 2, a[63:32]);
      j = '{a: a, l: len, s: s, e: e, c: c};
      if (push) exp_q.push_back(j);
   endtask

   task automatic wait_idle();
      int t = 0;
      while ((exp_q.size() != 0 || done_cnt != acc_cnt) && t < 2000) begin
         tick(); t++;
      end
      repeat (4) tick();
      chk(t < 2000, "R5 ring drained", 128'(t), 0);
   endtask

   task automatic wait_valid();
      int t = 0;
      while (!job_valid && t < 50) begin tick(); t++; end
   endtask

   // Monitor / scoreboard
   logic prev_v = 1'b0, prev_r = 1'b0;
   job_t prev_j;
   always @(negedge clk) begin
      job_t cur, e;
      cur = {job_addr, job_len, job_sop, job_eop, job_crc};
      if (rst_n) begin
         if (hold_en && prev_v && !prev_r)
            chk(job_valid && cur == prev_j, "R6 offer held", {job_valid, cur}, {1'b1, prev_j});
         if (job_valid && job_ready) begin
            if (exp_q.size() == 0) chk(0, "R5 unexpected job", cur, 0);
            else begin
               e = exp_q.pop_front();
               chk(cur == e, "R4/R5 job contents", cur, e);
            end
            acc_cnt++;
         end
      end
      prev_v = job_valid; prev_r = job_ready; prev_j = cur;
   end

   // Completion responder
   initial begin
      forever begin
         @(negedge clk);
         if (acc_cnt > done_cnt) begin
            @(posedge clk); @(posedge clk); #1 auto_d = 1'b1;
            @(posedge clk); #1 auto_d = 1'b0;
            done_cnt++;
         end
      end
   end

   initial begin
      #(4 * 100000);
      chk(0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      logic [31:0] d;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk(!job_valid, "R1 valid after reset", 128'(job_valid), 0);
      tick();
      rd(A_PROD, d); chk(d == 0, "R1 producer reset", d, 0);
      rd(A_CONS, d); chk(d == 0, "R1 consumer reset", d, 0);
      rd(A_CTRL, d); chk(d == 0, "R1 control reset", d, 0);

      // R2 descriptor storage layout
      put_desc(0, 12'h05C, 64'h0000_0012_3456_7890, 1, 1, 1, 1);
      rd(0, d); chk(d == mk_w0(12'h05C, 1, 1, 1), "R2 word 0", d, mk_w0(12'h05C, 1, 1, 1));
      rd(1, d); chk(d == 32'h3456_7890, "R2 word 1", d, 32'h3456_7890);
      rd(2, d); chk(d == 32'h0000_0012, "R2 word 2", d, 32'h12);
      put_desc(1, 12'hFFF, 64'hFEDC_BA98_7654_3210, 1, 0, 0, 1);
      put_desc(2, 12'h001, 64'h8000_0000_0000_0004, 0, 1, 1, 1);

      // R3 gating by each enable bit alone
      wr(A_CTRL, 32'h1);
      wr(A_PROD, 3);
      repeat (10) tick();
      chk(!job_valid, "R3 global enable only", 128'(job_valid), 0);
      wr(A_CTRL, 32'h0002_0000);
      repeat (10) tick();
      chk(!job_valid, "R3 ring enable only", 128'(job_valid), 0);
      wr(A_CTRL, RUN);
      wait_idle();
      rd(A_CONS, d); chk(d == 3, "R7 consumer after three jobs", d, 3);

      // R7 done with nothing in flight
      man_d = 1'b1; tick(); man_d = 1'b0;
      repeat (3) tick();
      rd(A_CONS, d); chk(d == 3, "R7 stray done ignored", d, 3);

      // R10 consumer write while enabled
      wr(A_CONS, 32'h55);
      rd(A_CONS, d); chk(d == 3, "R10 consumer write ignored", d, 3);

      // R6 back-pressure
      rdy = 1'b0;
      put_desc(3, 12'h2A0, 64'h0000_0001_0000_0800, 1, 1, 0, 1);
      wr(A_PROD, 4);
      wait_valid();
      repeat (6) tick();
      chk(job_valid, "R6 still offered under back-pressure", 128'(job_valid), 1);
      rdy = 1'b1;
      wait_idle();
      rd(A_CONS, d); chk(d == 4, "R7 consumer after stall", d, 4);

      // R8/R5 wrap of indices and ring slot
      wr(A_CTRL, 0);
      wr(A_CONS, 32'hFFFE);
      wr(A_PROD, 32'hFFFE);
      rd(A_CONS, d); chk(d == 32'hFFFE, "R10 consumer write while disabled", d, 32'hFFFE);
      put_desc(254, 12'h100, 64'h0000_00AA_0000_1000, 1, 0, 1, 1);
      put_desc(255, 12'h200, 64'h0000_00BB_0000_2000, 0, 0, 0, 1);
      put_desc(0,   12'h300, 64'h0000_00CC_0000_3000, 0, 1, 1, 1);
      wr(A_PROD, 32'h0001);
      repeat (10) tick();
      chk(!job_valid, "R3 disabled with work pending", 128'(job_valid), 0);
      wr(A_CTRL, RUN);
      wait_idle();
      rd(A_CONS, d); chk(d == 1, "R8 consumer wrapped", d, 1);

      // R9 flush ignored while enabled
      wr(A_FLUSH, 1);
      rd(A_PROD, d); chk(d == 1, "R9 flush ignored when enabled", d, 1);

      // R9 flush withdraws an offered job
      rdy = 1'b0; hold_en = 1'b0;
      put_desc(1, 12'h0F0, 64'h0000_0000_DEAD_0000, 1, 1, 1, 0);
      wr(A_PROD, 2);
      wait_valid();
      chk(job_valid, "R3 job offered before flush", 128'(job_valid), 1);
      wr(A_CTRL, 0);
      wr(A_FLUSH, 1);
      @(negedge clk);
      chk(!job_valid, "R9 offer withdrawn", 128'(job_valid), 0);
      tick();
      rd(A_PROD, d); chk(d == 0, "R9 producer cleared", d, 0);
      rd(A_CONS, d); chk(d == 0, "R9 consumer cleared", d, 0);
      rdy = 1'b1; hold_en = 1'b1;
      wr(A_CTRL, RUN);
      repeat (10) tick();
      chk(!job_valid, "R9 no work after flush", 128'(job_valid), 0);
      chk(exp_q.size() == 0, "R5 all expected jobs seen", 128'(exp_q.size()), 0);

      summary();
   end
endmodule